// File: doc/BRIEF.md
# Frame Address Field Decoder

This block sits behind a serial-link receiver that has already removed flags and stuffing. It sees the frame as a stream of bytes, each qualified by a valid strobe, with a start-of-frame strobe on the first byte. The block reads the destination address at the head of the frame. That address is variable in length. Bit 0 of every address byte is set on the last address byte. Bit 1 of the first byte is the single command/response bit. The first byte gives the six low channel bits. Each further byte adds seven higher bits.

When the address ends, the block issues a one-cycle pulse. With the pulse it gives the channel number, the command/response bit, and whether the channel equals a configured local channel. The bytes that follow, including any check-sequence bytes, are forwarded unchanged as payload, but only for frames that match. An address longer than the supported number of bytes raises a one-cycle overflow pulse, and the rest of that frame is dropped. A start-of-frame byte always begins a new parse, whatever state the block is in.

Top module: `addr_field_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, every output is zero. This holds until a byte is accepted.
- R2: A start-of-frame byte with bit 0 set is a complete address. One cycle after the edge that accepts it, hdr_done pulses. hdr_chan then carries bits 7:2 of that byte, zero-extended, and hdr_cr carries its bit 1.
- R3: Extension bytes follow a first byte whose bit 0 is clear. The second address byte supplies hdr_chan bits 12:6 from its bits 7:1. The third supplies hdr_chan bits 19:13. hdr_done pulses one cycle after the byte that has bit 0 set.
- R4: hdr_cr is taken only from bit 1 of the first address byte. Bit 1 of an extension byte is a channel bit and does not change hdr_cr.
- R5: The third address byte may arrive with bit 0 clear. addr_ovf then pulses one cycle later and hdr_done does not pulse. No byte of that frame is forwarded.
- R6: With hdr_done, hdr_match is 1 exactly when the decoded channel equals local_chan. hdr_chan, hdr_cr and hdr_match hold their values until the next hdr_done.
- R7: In a matching frame, each later valid byte appears on pl_data with pl_valid one cycle after it is accepted. Its value is unchanged, and this includes the final check-sequence bytes.
- R8: A frame whose channel does not match forwards no bytes.
- R9: A start-of-frame byte restarts address parsing at any point, including in the middle of an address. The interrupted frame produces no pulse.
- R10: Cycles with in_valid low have no effect. This includes cycles with in_sof high. Valid bytes without in_sof that arrive outside a frame's address or payload are also ignored.
- R11: hdr_done, addr_ovf and pl_valid are never high together. After addr_ovf, pl_valid stays low until a new frame matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the receiver |
| in_sof | input | 1 | Marks the first byte of a frame (qualified by in_valid) |
| in_data | input | 8 | Received byte |
| local_chan | input | 20 | Channel this node answers to |
| hdr_done | output | 1 | One-cycle pulse: address field complete |
| hdr_chan | output | 20 | Decoded channel, zero-extended |
| hdr_cr | output | 1 | Command/response bit of the frame |
| hdr_match | output | 1 | Decoded channel equals local_chan |
| addr_ovf | output | 1 | One-cycle pulse: address longer than supported |
| pl_valid | output | 1 | Forwarded payload byte strobe |
| pl_data | output | 8 | Forwarded payload byte |

## Verification
The assertions assume the receiver presents at most one byte per cycle. They also assume in_sof carries meaning only together with in_valid, and that local_chan is steady while a frame's address is being read. The stimulus meets these assumptions. It changes local_chan only between frames, during idle cycles, and drives each byte for exactly one cycle. In some runs it inserts idle cycles, or an in_sof without in_valid, to exercise the cases where input must be ignored. Frames are cut off mid-address or run past the address limit, so the restart and overflow paths are reached.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_PASS = 2'd2,
    ST_DROP = 2'd3
  } dec_state_e;

  localparam int FIRST_BITS = 6;
  localparam int EXT_BITS   = 7;

  function automatic int chan_width(input int n_bytes);
    return FIRST_BITS + EXT_BITS * (n_bytes - 1);
  endfunction
endpackage

// File: rtl/addr_dec_accum.sv
module addr_dec_accum
  import addr_dec_pkg::*;
#(
  parameter int MAX_BYTES = 3,
  parameter int CHAN_W    = chan_width(MAX_BYTES),
  parameter int IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first,
  input  logic              acc_en,
  input  logic [7:0]        data,
  output logic [CHAN_W-1:0] chan_cur,
  output logic              cr_cur,
  output logic              last_slot
);
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_cur;
  logic              cr_q, cr_d;

  assign idx_cur   = first ? '0 : idx_q;
  assign last_slot = (idx_cur == IDX_W'(MAX_BYTES - 1));
  assign cr_cur    = first ? data[1] : cr_q;
  assign chan_cur[FIRST_BITS-1:0] = first ? data[7:2] : chan_q[FIRST_BITS-1:0];

  for (genvar k = 1; k < MAX_BYTES; k++) begin : g_ext
    localparam int LO = FIRST_BITS + EXT_BITS * (k - 1);
    assign chan_cur[LO +: EXT_BITS] =
      first                    ? '0        :
      (idx_q == IDX_W'(k))     ? data[7:1] :
                                 chan_q[LO +: EXT_BITS];
  end

  always_comb begin
    chan_d = chan_q;
    idx_d  = idx_q;
    cr_d   = cr_q;
    if (acc_en) begin
      chan_d = chan_cur;
      idx_d  = idx_cur + IDX_W'(1);
      cr_d   = cr_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      idx_q  <= '0;
      cr_q   <= 1'b0;
    end else begin
      chan_q <= chan_d;
      idx_q  <= idx_d;
      cr_q   <= cr_d;
    end
  end
endmodule

// File: rtl/addr_dec_ctrl.sv
module addr_dec_ctrl
  import addr_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  input  logic term,
  input  logic last_slot,
  input  logic match,
  output logic first,
  output logic acc_en,
  output logic done_now,
  output logic ovf_now,
  output logic pass_now
);
  dec_state_e state_q, state_d;

  assign first    = in_valid & in_sof;
  assign acc_en   = first | (in_valid & (state_q == ST_ADDR));
  assign done_now = acc_en & term;
  assign ovf_now  = acc_en & ~term & last_slot;
  assign pass_now = in_valid & ~in_sof & (state_q == ST_PASS);

  always_comb begin
    state_d = state_q;
    if (acc_en) begin
      if (term)           state_d = match ? ST_PASS : ST_DROP;
      else if (last_slot) state_d = ST_DROP;
      else                state_d = ST_ADDR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/addr_dec_out.sv
module addr_dec_out #(
  parameter int CHAN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_now,
  input  logic              ovf_now,
  input  logic              pass_now,
  input  logic [CHAN_W-1:0] chan_cur,
  input  logic              cr_cur,
  input  logic              match,
  input  logic [7:0]        data,
  output logic              hdr_done,
  output logic [CHAN_W-1:0] hdr_chan,
  output logic              hdr_cr,
  output logic              hdr_match,
  output logic              addr_ovf,
  output logic              pl_valid,
  output logic [7:0]        pl_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_done <= 1'b0;
      addr_ovf <= 1'b0;
      pl_valid <= 1'b0;
    end else begin
      hdr_done <= done_now;
      addr_ovf <= ovf_now;
      pl_valid <= pass_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_chan  <= '0;
      hdr_cr    <= 1'b0;
      hdr_match <= 1'b0;
    end else if (done_now) begin
      hdr_chan  <= chan_cur;
      hdr_cr    <= cr_cur;
      hdr_match <= match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pl_data <= '0;
    else if (pass_now) pl_data <= data;
  end
endmodule

// File: rtl/addr_field_decoder.sv
module addr_field_decoder
  import addr_dec_pkg::*;
#(
  parameter int MAX_BYTES = 3,
  parameter int CHAN_W    = chan_width(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [7:0]        in_data,
  input  logic [CHAN_W-1:0] local_chan,
  output logic              hdr_done,
  output logic [CHAN_W-1:0] hdr_chan,
  output logic              hdr_cr,
  output logic              hdr_match,
  output logic              addr_ovf,
  output logic              pl_valid,
  output logic [7:0]        pl_data
);
  logic              first, acc_en, done_now, ovf_now, pass_now;
  logic              cr_cur, last_slot, match;
  logic [CHAN_W-1:0] chan_cur;

  assign match = (chan_cur == local_chan);

  addr_dec_accum #(.MAX_BYTES(MAX_BYTES), .CHAN_W(CHAN_W)) u_accum (
    .clk, .rst_n, .first, .acc_en, .data(in_data),
    .chan_cur, .cr_cur, .last_slot
  );

  addr_dec_ctrl u_ctrl (
    .clk, .rst_n, .in_valid, .in_sof, .term(in_data[0]),
    .last_slot, .match, .first, .acc_en, .done_now, .ovf_now, .pass_now
  );

  addr_dec_out #(.CHAN_W(CHAN_W)) u_out (
    .clk, .rst_n, .done_now, .ovf_now, .pass_now, .chan_cur, .cr_cur,
    .match, .data(in_data), .hdr_done, .hdr_chan, .hdr_cr, .hdr_match,
    .addr_ovf, .pl_valid, .pl_data
  );
endmodule

// File: rtl/addr_dec_chk.sv
module addr_dec_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sof,
  input logic hdr_done,
  input logic hdr_match,
  input logic addr_ovf,
  input logic pl_valid
);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!hdr_done && !addr_ovf && !pl_valid));

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hdr_done, addr_ovf, pl_valid}) <= 1);

  // R8
  fwd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> hdr_match);

  // R5
  no_fwd_after_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ovf |=> !pl_valid);

  // R9
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !pl_valid);

  // R6
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_done && $past(rst_n)) |-> $stable(hdr_match));
endmodule

bind addr_field_decoder addr_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .hdr_done(hdr_done), .hdr_match(hdr_match), .addr_ovf(addr_ovf),
  .pl_valid(pl_valid)
);

// File: tb/addr_field_decoder_test.sv
`timescale 1ns/1ps
module addr_field_decoder_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_sof;
  logic [7:0]  in_data;
  logic [19:0] local_chan;
  logic        hdr_done;
  logic [19:0] hdr_chan;
  logic        hdr_cr;
  logic        hdr_match;
  logic        addr_ovf;
  logic        pl_valid;
  logic [7:0]  pl_data;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    int          kind;   // 0 header, 1 payload, 2 overflow
    logic [19:0] chan;
    logic        cr;
    logic        match;
    logic [7:0]  data;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  addr_field_decoder uut (
    .clk, .rst_n, .in_valid, .in_sof, .in_data, .local_chan,
    .hdr_done, .hdr_chan, .hdr_cr, .hdr_match, .addr_ovf, .pl_valid, .pl_data
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R0 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic push(input int kind, input logic [19:0] chan, input logic cr,
                      input logic match, input logic [7:0] data, input string req);
    exp_t e;
    e.kind = kind; e.chan = chan; e.cr = cr; e.match = match;
    e.data = data; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic compare(input int kind);
    exp_t e;
    n_tests++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R10 unexpected event: actual kind=%0d expected=none", kind);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != kind) begin
      n_fail++;
      $display("FAIL %s event kind: actual=%0d expected=%0d", e.req, kind, e.kind);
    end else if (kind == 0 && (hdr_chan != e.chan || hdr_cr != e.cr || hdr_match != e.match)) begin
      n_fail++;
      $display("FAIL %s header: actual chan=%h cr=%0b match=%0b expected chan=%h cr=%0b match=%0b",
               e.req, hdr_chan, hdr_cr, hdr_match, e.chan, e.cr, e.match);
    end else if (kind == 1 && pl_data != e.data) begin
      n_fail++;
      $display("FAIL %s payload: actual=%h expected=%h", e.req, pl_data, e.data);
    end
  endtask

  always @(posedge clk) begin : monitor
    #2;
    if (rst_n) begin
      if (hdr_done) compare(0);
      if (addr_ovf) compare(2);
      if (pl_valid) compare(1);
    end
  end

  task automatic drive_byte(input logic sof, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_data = 8'h00;
    end
  endtask

  function automatic logic [7:0] pick(input int i, input logic [7:0] a0, a1, a2, a3);
    case (i)
      0: return a0;
      1: return a1;
      2: return a2;
      default: return a3;
    endcase
  endfunction

  // Expected results come from R2..R8: 6 bits from byte 0, 7 per extension byte.
  task automatic send_frame(input int na, input logic [7:0] a0, a1, a2, a3,
                            input int npay, input logic [7:0] seed, input bit gaps,
                            input string req);
    logic [19:0] chan = '0;
    logic        cr   = a0[1];
    bit          term = 0;
    bit          ovf  = 0;
    bit          m;
    for (int i = 0; i < na && !term && !ovf; i++) begin
      logic [7:0] b = pick(i, a0, a1, a2, a3);
      if (i == 0) chan[5:0] = b[7:2];
      else        chan[6 + 7*(i-1) +: 7] = b[7:1];
      if (b[0]) term = 1;
      else if (i == 2) ovf = 1;
    end
    m = (chan == local_chan);
    if (term) begin
      push(0, chan, cr, m, 8'h00, req);
      if (m) for (int i = 0; i < npay; i++) push(1, '0, 0, 0, seed + 8'(i), "R7");
    end
    if (ovf) push(2, '0, 0, 0, 8'h00, "R5");
    for (int i = 0; i < na; i++) drive_byte(i == 0, pick(i, a0, a1, a2, a3));
    for (int i = 0; i < npay; i++) begin
      if (gaps) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b1; in_data = 8'h01;  // R10 sof without valid
      end
      drive_byte(1'b0, seed + 8'(i));
    end
  endtask

  task automatic expect_drained(input string req);
    idle(3);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing events: actual pending=%0d expected=0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0; local_chan = '0;
    repeat (3) @(negedge clk);
    n_tests++;  // R1 during reset
    if ({hdr_done, hdr_chan, hdr_cr, hdr_match, addr_ovf, pl_valid, pl_data} != '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: actual=%h expected=0",
               {hdr_done, hdr_chan, hdr_cr, hdr_match, addr_ovf, pl_valid, pl_data});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_tests++;  // R1 after release
    if ({hdr_done, hdr_chan, hdr_cr, hdr_match, addr_ovf, pl_valid, pl_data} != '0) begin
      n_fail++;
      $display("FAIL R1 post-reset outputs: actual=%h expected=0",
               {hdr_done, hdr_chan, hdr_cr, hdr_match, addr_ovf, pl_valid, pl_data});
    end

    // R10: stray bytes without sof before any frame
    drive_byte(1'b0, 8'hA5); drive_byte(1'b0, 8'h11);
    expect_drained("R10");

    // R2, R7: single-byte address, matching, payload ends with check bytes
    local_chan = 20'h00029;
    send_frame(1, 8'hA5, 0, 0, 0, 4, 8'h30, 0, "R2");
    expect_drained("R7");

    // R2, R8: single-byte, cr set, not matching
    send_frame(1, 8'h17, 0, 0, 0, 3, 8'h50, 0, "R8");
    expect_drained("R8");

    // R10: bytes after a dropped frame stay ignored
    drive_byte(1'b0, 8'h77);
    expect_drained("R10");

    // R3, R10: two-byte address, payload with gaps and sof-without-valid
    local_chan = {7'h25, 6'h2C};
    send_frame(2, 8'hB2, 8'h4B, 0, 0, 3, 8'h60, 1, "R3");
    expect_drained("R3");

    // R3, R4: three-byte address, extension bit 1 set, cr from byte 0 only
    local_chan = 20'h03FFF;
    send_frame(3, 8'hFC, 8'hFE, 8'h03, 0, 2, 8'h70, 0, "R4");
    expect_drained("R4");

    // R5: address too long, rest of frame dropped
    send_frame(4, 8'h04, 8'h02, 8'h02, 8'h01, 3, 8'h80, 0, "R5");
    expect_drained("R5");

    // R9: sof mid-address restarts parsing
    local_chan = 20'h0000B;
    send_frame(2, 8'h08, 8'h10, 0, 0, 0, 8'h00, 0, "R9");
    send_frame(1, 8'h2D, 0, 0, 0, 2, 8'h90, 0, "R9");
    expect_drained("R9");

    // R9: sof mid-payload starts a new, non-matching frame
    send_frame(1, 8'h2D, 0, 0, 0, 1, 8'hA0, 0, "R9");
    send_frame(1, 8'h11, 0, 0, 0, 2, 8'hB0, 0, "R9");
    expect_drained("R9");

    // R6, R8: all-ones channel vs neighbour value, no forwarding
    local_chan = 20'hFFFFE;
    send_frame(3, 8'hFE, 8'hFE, 8'hFF, 0, 2, 8'hC0, 0, "R6");
    expect_drained("R6");

    // R6: header outputs hold after the pulse
    n_tests++;
    if (hdr_chan != 20'hFFFFF || hdr_cr != 1'b1 || hdr_match != 1'b0) begin
      n_fail++;
      $display("FAIL R6 held header: actual chan=%h cr=%0b match=%0b expected chan=fffff cr=1 match=0",
               hdr_chan, hdr_cr, hdr_match);
    end

    summary();
    $finish;
  end
endmodule